// File: doc/BRIEF.md
# Dual-Port Mailbox Register Bank

This block is a bank of shared byte registers between two bus agents: a host port and a management-controller port. Both sides can read and write every data register. Messages are passed by filling the data registers and then ringing a doorbell. By convention, bytes 0 and 1 hold a command and a sequence tag, bytes 2 to 12 hold arguments, byte 13 holds a response code, byte 14 holds host status and byte 15 holds controller status. The bank itself gives no meaning to these fields.

Each side has a private set of registers behind the same addresses:
- A control register.
- Write-interrupt enable bytes.
- Write-interrupt mask bytes.
- Write-status bytes.

Writing the ring bit of a control register raises a flag in the other side's control register. Separately, each data-register write by one side records a status bit for the other side. Each side has one interrupt line. It combines its doorbell flag with every recorded write-status bit that is enabled and not masked. A side can poll its flag bit instead of using the interrupt.

Top module: `mbox_bank_top`

## Requirements
- R1: After synchronous reset, every data register, flag, enable, mask and status bit is 0, both interrupt lines are low and both read-data outputs are 0.
- R2: Address 0x00 to 0x0F selects data registers 0 to 15. A write from either port becomes visible to reads on both ports. Read data appears on the cycle after the read strobe and shows the state from before that edge.
- R3: When both ports write the same data register in the same cycle, the controller port's value is stored.
- R4: Writing address 0x10 with bit 0 set rings the other side. From the next cycle, the other side's control register reads bit 7 = 1 and its interrupt line is high.
- R5: A side clears its own bit 7 by writing 0x10 with bit 7 set. Its interrupt drops in the next cycle unless a write-status source remains. If a ring from the peer arrives in the same cycle, bit 7 stays set.
- R6: Reading 0x10 returns the flag in bit 7 and 0 in all other bits. Bit 0 is not stored, and writes to bits 1 to 6 have no effect.
- R7: A data-register write by one side sets bit i of the other side's write status, whatever the enable and mask settings. Here i is the register index, and bit i sits at address 0x15 + i/8, bit position i%8.
- R8: A side's interrupt equals its bit 7 ORed with any write-status bit whose enable bit is 1 and whose mask bit is 0. Enable bits are at 0x11 and 0x12, and mask bits at 0x13 and 0x14, with the same bit mapping as R7.
- R9: Writing 1 to a write-status bit clears it, and writing 0 leaves it alone. If a new peer write sets the bit in the same cycle, the set wins.
- R10: A side's own data-register writes never set its own write-status bits.
- R11: Addresses 0x17 to 0x1F read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| h_irq | output | 1 | Interrupt toward host |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe |
| c_addr | input | 5 | Controller register address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, registered |
| c_irq | output | 1 | Interrupt toward controller |

## Verification
Two pairs of events can land in one cycle: a write by each port to the same data register, and a status set (a ring or peer data write) arriving with the receiving side's write-1-to-clear. The bench drives both strobes on the same edge for each pair. It then reads the result back through the ports, expecting the controller's byte for the data collision and a still-set bit for the clear collision. A behavioural model of both register files is also compared with both read buses and both interrupt lines on every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int RING_BIT = 0;
  localparam int FLAG_BIT = 7;

  typedef enum logic [2:0] {
    K_DATA,
    K_CTRL,
    K_EN,
    K_MASK,
    K_STAT,
    K_NONE
  } reg_kind_e;

  // Map: data regs, then control, then enable, mask and status groups.
  function automatic reg_kind_e decode_kind(input int a, input int nregs, input int ngrp);
    if (a < nregs)                     return K_DATA;
    else if (a == nregs)               return K_CTRL;
    else if (a < nregs + 1 + ngrp)     return K_EN;
    else if (a < nregs + 1 + 2 * ngrp) return K_MASK;
    else if (a < nregs + 1 + 3 * ngrp) return K_STAT;
    else                               return K_NONE;
  endfunction

endpackage

// File: rtl/mbox_data_bank.sv
module mbox_data_bank #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          h_wr,
  input  logic [AW-1:0]                 h_addr,
  input  logic [DW-1:0]                 h_wdata,
  input  logic                          c_wr,
  input  logic [AW-1:0]                 c_addr,
  input  logic [DW-1:0]                 c_wdata,
  output logic [NUM_REGS-1:0][DW-1:0]   regs_o,
  output logic [NUM_REGS-1:0]           h_hit,
  output logic [NUM_REGS-1:0]           c_hit
);

  logic [NUM_REGS-1:0][DW-1:0] regs_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign h_hit[i] = h_wr && (h_addr == AW'(i));
    assign c_hit[i] = c_wr && (c_addr == AW'(i));

    // Controller side takes priority on a same-register collision.
    always_ff @(posedge clk) begin
      if (rst)           regs_q[i] <= '0;
      else if (c_hit[i]) regs_q[i] <= c_wdata;
      else if (h_hit[i]) regs_q[i] <= h_wdata;
    end
  end

  assign regs_o = regs_q;

endmodule

// File: rtl/mbox_side_regs.sv
module mbox_side_regs
  import mbox_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic                peer_ring,
  input  logic [NUM_REGS-1:0] peer_hit,
  output logic                ring,
  output logic                flag,
  output logic                irq,
  output logic [DW-1:0]       rdata
);

  localparam int NGRP   = (NUM_REGS + DW - 1) / DW;
  localparam int PADW   = NGRP * DW;
  localparam int GW     = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int CTRL_A = NUM_REGS;
  localparam int EN_A   = NUM_REGS + 1;
  localparam int MASK_A = EN_A + NGRP;
  localparam int STAT_A = MASK_A + NGRP;

  reg_kind_e kind;
  logic [GW-1:0] grp;

  logic                      flag_q;
  logic [NGRP-1:0][DW-1:0]   en_q;
  logic [NGRP-1:0][DW-1:0]   mask_q;
  logic [NGRP-1:0][DW-1:0]   stat_q;
  logic [NGRP-1:0][DW-1:0]   clr_vec;
  logic [PADW-1:0]           hit_pad;

  always_comb begin
    kind = decode_kind(int'(addr), NUM_REGS, NGRP);
    unique case (kind)
      K_EN:    grp = GW'(addr - AW'(EN_A));
      K_MASK:  grp = GW'(addr - AW'(MASK_A));
      K_STAT:  grp = GW'(addr - AW'(STAT_A));
      default: grp = '0;
    endcase
  end

  assign ring    = wr && (kind == K_CTRL) && wdata[RING_BIT];
  assign hit_pad = PADW'(peer_hit);

  // Peer ring has priority over the local write-1 clear.
  always_ff @(posedge clk) begin
    if (rst)                                           flag_q <= 1'b0;
    else if (peer_ring)                                flag_q <= 1'b1;
    else if (wr && (kind == K_CTRL) && wdata[FLAG_BIT]) flag_q <= 1'b0;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign clr_vec[g] = (wr && (kind == K_STAT) && (grp == GW'(g))) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]   <= '0;
        mask_q[g] <= '0;
      end else begin
        if (wr && (kind == K_EN) && (grp == GW'(g)))   en_q[g]   <= wdata;
        if (wr && (kind == K_MASK) && (grp == GW'(g))) mask_q[g] <= wdata;
      end
    end
  end

  // Set beats clear on the same bit.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_vec) | hit_pad;
  end

  assign flag = flag_q;
  assign irq  = flag_q | (|(stat_q & en_q & ~mask_q));

  always_comb begin
    rdata = '0;
    unique case (kind)
      K_CTRL:  rdata[FLAG_BIT] = flag_q;
      K_EN:    rdata = en_q[grp];
      K_MASK:  rdata = mask_q[grp];
      K_STAT:  rdata = stat_q[grp];
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbox_bank_top.sv
module mbox_bank_top #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          c_wr,
  input  logic          c_rd,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          c_irq
);

  localparam int IW = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DW-1:0] bank_regs;
  logic [NUM_REGS-1:0]         h_hit, c_hit;
  logic                        h_ring, c_ring, h_flag, c_flag;
  logic [DW-1:0]               h_side_rd, c_side_rd;

  mbox_data_bank #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) bank_i (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .c_wr(c_wr), .c_addr(c_addr), .c_wdata(c_wdata),
    .regs_o(bank_regs), .h_hit(h_hit), .c_hit(c_hit)
  );

  mbox_side_regs #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) side_h_i (
    .clk(clk), .rst(rst),
    .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
    .peer_ring(c_ring), .peer_hit(c_hit),
    .ring(h_ring), .flag(h_flag), .irq(h_irq), .rdata(h_side_rd)
  );

  mbox_side_regs #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) side_c_i (
    .clk(clk), .rst(rst),
    .wr(c_wr), .addr(c_addr), .wdata(c_wdata),
    .peer_ring(h_ring), .peer_hit(h_hit),
    .ring(c_ring), .flag(c_flag), .irq(c_irq), .rdata(c_side_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rdata <= '0;
      c_rdata <= '0;
    end else begin
      if (h_rd) h_rdata <= (h_addr < AW'(NUM_REGS)) ? bank_regs[h_addr[IW-1:0]] : h_side_rd;
      if (c_rd) c_rdata <= (c_addr < AW'(NUM_REGS)) ? bank_regs[c_addr[IW-1:0]] : c_side_rd;
    end
  end

endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int NUM_REGS = 16,
  parameter int DW       = 8,
  parameter int AW       = 5
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        h_wr,
  input logic                        h_rd,
  input logic [AW-1:0]               h_addr,
  input logic [DW-1:0]               h_wdata,
  input logic [DW-1:0]               h_rdata,
  input logic                        h_irq,
  input logic                        c_wr,
  input logic                        c_rd,
  input logic [AW-1:0]               c_addr,
  input logic [DW-1:0]               c_wdata,
  input logic [DW-1:0]               c_rdata,
  input logic                        c_irq,
  input logic [NUM_REGS-1:0][DW-1:0] regs,
  input logic                        c_flag
);

  localparam int NGRP = (NUM_REGS + DW - 1) / DW;
  localparam int IW   = $clog2(NUM_REGS);
  localparam logic [AW-1:0] CTRL_A = AW'(NUM_REGS);
  localparam logic [AW-1:0] LAST_A = AW'(NUM_REGS + 3 * NGRP);

  // R4
  host_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_addr == CTRL_A && h_wdata[0]) |=> (c_irq && c_flag));

  // R4
  ctrl_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && c_addr == CTRL_A && c_wdata[0]) |=> h_irq);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr && c_addr == CTRL_A && c_wdata[7] && !(h_wr && h_addr == CTRL_A && h_wdata[0]))
      |=> !c_flag);

  // R3
  collide_chk: assert property (@(posedge clk) disable iff (rst)
    (h_wr && c_wr && h_addr == c_addr && c_addr < AW'(NUM_REGS))
      |=> (regs[$past(c_addr[IW-1:0])] == $past(c_wdata)));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (h_rd && h_addr > LAST_A) |=> (h_rdata == '0));

  // R6
  ctrl_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (c_rd && c_addr == CTRL_A) |=> (c_rdata[6:0] == '0));

endmodule

bind mbox_bank_top mbox_bank_chk #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst),
  .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
  .h_rdata(h_rdata), .h_irq(h_irq),
  .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
  .c_rdata(c_rdata), .c_irq(c_irq),
  .regs(bank_regs), .c_flag(c_flag)
);

// File: tb/mbox_bank_top_tb_top.sv
module mbox_bank_top_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic       h_wr, h_rd, c_wr, c_rd;
  logic [4:0] h_addr, c_addr;
  logic [7:0] h_wdata, c_wdata;
  logic [7:0] h_rdata, c_rdata;
  logic       h_irq, c_irq;

  mbox_bank_top dut_i (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq),
    .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_irq(c_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model: index 0 is the host, index 1 the controller.
  int        md[16];
  bit        mflag[2];
  bit [15:0] men[2], mmask[2], mstat[2];
  int        mrd[2];
  bit        started = 0;

  function automatic int mread(int p, int a);
    if (a < 16)  return md[a];
    if (a == 16) return mflag[p] ? 8'h80 : 0;
    if (a == 17) return men[p][7:0];
    if (a == 18) return men[p][15:8];
    if (a == 19) return mmask[p][7:0];
    if (a == 20) return mmask[p][15:8];
    if (a == 21) return mstat[p][7:0];
    if (a == 22) return mstat[p][15:8];
    return 0;
  endfunction

  function automatic bit mirq(int p);
    return mflag[p] || ((mstat[p] & men[p] & ~mmask[p]) != 0);
  endfunction

  always @(posedge clk) begin
    bit w[2];
    bit r[2];
    int a[2];
    int d[2];
    bit rg[2];
    w[0] = h_wr; r[0] = h_rd; a[0] = h_addr; d[0] = h_wdata;
    w[1] = c_wr; r[1] = c_rd; a[1] = c_addr; d[1] = c_wdata;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 16; i++) md[i] = 0;
      for (int p = 0; p < 2; p++) begin
        mflag[p] = 0; men[p] = 0; mmask[p] = 0; mstat[p] = 0; mrd[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) if (r[p]) mrd[p] = mread(p, a[p]);
      for (int p = 0; p < 2; p++) rg[p] = w[p] && a[p] == 16 && d[p][0];
      for (int p = 0; p < 2; p++) begin
        if (w[p] && a[p] == 16 && d[p][7]) mflag[p] = 0;
        if (rg[1-p]) mflag[p] = 1;
        if (w[p] && a[p] == 17) men[p][7:0]    = d[p][7:0];
        if (w[p] && a[p] == 18) men[p][15:8]   = d[p][7:0];
        if (w[p] && a[p] == 19) mmask[p][7:0]  = d[p][7:0];
        if (w[p] && a[p] == 20) mmask[p][15:8] = d[p][7:0];
        if (w[p] && a[p] == 21) mstat[p][7:0]  = mstat[p][7:0] & ~d[p][7:0];
        if (w[p] && a[p] == 22) mstat[p][15:8] = mstat[p][15:8] & ~d[p][7:0];
        if (w[1-p] && a[1-p] < 16) mstat[p][a[1-p]] = 1'b1;
      end
      if (w[0] && a[0] < 16) md[a[0]] = d[0];
      if (w[1] && a[1] < 16) md[a[1]] = d[1];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R2 R8 model).
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 model h_rdata", h_rdata, mrd[0]);
      chk("R2 model c_rdata", c_rdata, mrd[1]);
      chk("R8 model h_irq", h_irq, mirq(0));
      chk("R8 model c_irq", c_irq, mirq(1));
    end
  end

  task automatic hw(int a, int d);
    h_wr = 1; h_addr = a[4:0]; h_wdata = d[7:0];
    @(negedge clk);
    h_wr = 0;
  endtask

  task automatic cw(int a, int d);
    c_wr = 1; c_addr = a[4:0]; c_wdata = d[7:0];
    @(negedge clk);
    c_wr = 0;
  endtask

  task automatic both(int ha, int hd, int ca, int cd);
    h_wr = 1; h_addr = ha[4:0]; h_wdata = hd[7:0];
    c_wr = 1; c_addr = ca[4:0]; c_wdata = cd[7:0];
    @(negedge clk);
    h_wr = 0; c_wr = 0;
  endtask

  task automatic hr(int a, string tag, int exp);
    h_rd = 1; h_addr = a[4:0];
    @(negedge clk);
    h_rd = 0;
    chk(tag, h_rdata, exp);
  endtask

  task automatic cr(int a, string tag, int exp);
    c_rd = 1; c_addr = a[4:0];
    @(negedge clk);
    c_rd = 0;
    chk(tag, c_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1; h_wr = 0; h_rd = 0; c_wr = 0; c_rd = 0;
    h_addr = 0; c_addr = 0; h_wdata = 0; c_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 h_irq", h_irq, 0);
    chk("R1 c_irq", c_irq, 0);
    chk("R1 h_rdata", h_rdata, 0);
    hr(5, "R1 data5", 0);
    cr(16, "R1 ctrl", 0);

    hw(0, 8'hA5);
    cr(0, "R2 host->ctrl", 8'hA5);
    cw(13, 8'h3C);
    hr(13, "R2 ctrl->host", 8'h3C);

    both(7, 8'h11, 7, 8'h22);
    hr(7, "R3 host view", 8'h22);
    cr(7, "R3 ctrl view", 8'h22);

    cr(21, "R7 ctrl stat lo", 8'h81);
    cr(22, "R7 ctrl stat hi", 8'h00);
    chk("R8 no enable", c_irq, 0);
    hr(21, "R10 host stat lo", 8'h80);
    hr(22, "R7 host stat hi", 8'h20);

    cw(17, 8'h80);
    chk("R8 enabled", c_irq, 1);
    cw(19, 8'h80);
    chk("R8 masked", c_irq, 0);
    cw(19, 8'h00);
    chk("R8 unmasked", c_irq, 1);
    cw(21, 8'h80);
    chk("R9 w1c irq", c_irq, 0);
    cr(21, "R9 w1c stat", 8'h01);
    both(0, 8'h5A, 21, 8'h01);
    cr(21, "R9 set wins", 8'h01);
    cw(21, 8'h01);
    cr(21, "R9 cleared", 8'h00);

    hw(16, 8'h01);
    chk("R4 c_irq", c_irq, 1);
    chk("R4 h_irq quiet", h_irq, 0);
    cr(16, "R4 ctrl flag", 8'h80);
    hr(16, "R6 ring bit", 8'h00);
    hw(16, 8'h7E);
    hr(16, "R6 other bits", 8'h00);
    chk("R6 peer untouched", c_irq, 1);
    cw(16, 8'h80);
    chk("R5 clear", c_irq, 0);
    hw(16, 8'h01);
    both(16, 8'h01, 16, 8'h80);
    chk("R5 ring beats clear", c_irq, 1);
    cw(16, 8'h80);
    chk("R5 clear again", c_irq, 0);
    cw(16, 8'h01);
    chk("R4 h_irq", h_irq, 1);
    hr(16, "R4 host flag", 8'h80);
    hw(16, 8'h80);
    chk("R5 host clear", h_irq, 0);

    hw(31, 8'hFF);
    hr(31, "R11 read 1F", 8'h00);
    hr(23, "R11 read 17", 8'h00);
    chk("R11 no irq", h_irq, 0);

    hw(18, 8'h20);
    chk("R8 host hi enable", h_irq, 1);
    hw(20, 8'h20);
    chk("R8 host hi mask", h_irq, 0);
    hr(20, "R8 mask readback", 8'h20);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule